// File: doc/BRIEF.md
# Token Ring Phase Enumerator

This block sits on the controller side of a multiphase converter. It learns how many phase cells are present by timing a token around a ring. Every phase cell runs on the same clock as the controller. The controller drives its token output into the first cell. Each cell registers the token for one clock and passes it on. The last cell feeds the controller's token input.

Out of reset the controller sends one token and counts clock periods until it comes back. That count is the phase count, so the common clock runs at the phase count times the per-phase switching rate. A return that is too early or too late, or no return at all, marks the chain as broken. When the count is good, the controller sends a token every N clocks and checks that each one comes back on its own lap. A return that is missing or unexpected raises a fault flag that stays set until reset.

Top module: `phase_ring_enum`

## Requirements
- R1: While rst_n is low, ring_tok_out, enum_done and chain_fault are 0 and phase_count is 0.
- R2: At the first rising clock edge after reset is released (the launch edge), ring_tok_out goes high for exactly one clock. No further token is sent until enumeration ends.
- R3: Take a ring of N single-register cells, 1 <= N <= 16. The token is sampled back at the (N+1)th edge after the launch edge. From that edge on, enum_done is 1, phase_count equals N, and ring_tok_out is high again. enum_done then stays high until reset.
- R4: A return sampled at a count outside 1..16 sets chain_fault and leaves enum_done low. The count is the number of edges after the launch edge minus one, so it is 0 for a direct loop and 17 or more for a ring that is too long.
- R5: If no token returns, chain_fault is set from the 33rd edge after the launch edge, and enum_done stays low. chain_fault is still 0 after the 32nd edge.
- R6: Once enumeration is done, ring_tok_out is high in exactly one clock out of every N, starting in the cycle where enum_done rises. For N = 1 it stays high all the time.
- R7: After enumeration, a return in a cycle where no lap completes, or a missing return where a lap completes, sets chain_fault. enum_done stays high and the token keeps circulating every N clocks.
- R8: chain_fault stays set until reset. After an enumeration fault, ring_tok_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock shared with every phase cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_tok_out | output | 1 | Token into the first phase cell |
| ring_tok_in | input | 1 | Token returning from the last phase cell |
| enum_done | output | 1 | High once a valid phase count is known |
| phase_count | output | 5 | Discovered number of phases (CNT_W bits) |
| chain_fault | output | 1 | Sticky ring fault flag |

## Verification
Some checks are made on every cycle. A fault, once raised, is never dropped. A reported count always lies in 1..16. Each fault event forces the flag on the next cycle and keeps done low when enumeration fails. Accepting a count both raises done and relaunches the token. In normal operation a token is never followed by another in the next clock while N exceeds one. The bench scenarios are needed to show the exact edges at which the count is taken, the timeout and the too-long rejection, and the one-in-N token pattern for several ring lengths. They also show that an injected extra or missing return is caught while circulation continues.

// File: rtl/ring_enum_pkg.sv
package ring_enum_pkg;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_SEEK = 2'd1,
    ST_RUN  = 2'd2,
    ST_DEAD = 2'd3
  } enum_state_e;

  // A returned lap length is acceptable only between 1 and max_ph
  function automatic logic lap_ok(input int unsigned lap, input int unsigned max_ph);
    return (lap >= 1) && (lap <= max_ph);
  endfunction

  // Next position of the circulating phase pointer, modulo n
  function automatic int unsigned ring_step(input int unsigned ph, input int unsigned n);
    return (ph + 1 >= n) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/seek_timer.sv
module seek_timer #(
  parameter int TMR_W   = 6,
  parameter int TIMEOUT = 32
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             count_en,
  output logic [TMR_W-1:0] value,
  output logic             expired
);
  assign expired = (value == TMR_W'(TIMEOUT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   value <= '0;
    else if (clear)               value <= '0;
    else if (count_en && !expired) value <= value + TMR_W'(1);
  end
endmodule

// File: rtl/ring_sequencer.sv
module ring_sequencer import ring_enum_pkg::*; #(
  parameter int CNT_W = 5
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [CNT_W-1:0] lap_len,
  output logic             launch_next,
  output logic             at_home,
  output logic             armed
);
  logic [CNT_W-1:0] ph;
  logic [CNT_W-1:0] ph_nxt;

  assign ph_nxt      = CNT_W'(ring_step(32'(ph), 32'(lap_len)));
  assign launch_next = (ph_nxt == '0);
  assign at_home     = (ph == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      armed <= 1'b0;
    end else if (start) begin
      ph    <= '0;
      armed <= 1'b0;
    end else if (active) begin
      ph    <= ph_nxt;
      armed <= armed | (ph == lap_len - CNT_W'(1));
    end
  end
endmodule

// File: rtl/fault_latch.sv
module fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/phase_ring_enum.sv
module phase_ring_enum import ring_enum_pkg::*; #(
  parameter int MAX_PHASES = 16,
  parameter int TIMEOUT    = 32
)(
  input  logic                                 clk,
  input  logic                                 rst_n,
  output logic                                 ring_tok_out,
  input  logic                                 ring_tok_in,
  output logic                                 enum_done,
  output logic [$clog2(MAX_PHASES+1)-1:0]      phase_count,
  output logic                                 chain_fault
);
  localparam int CNT_W = $clog2(MAX_PHASES + 1);
  localparam int TMR_W = $clog2(TIMEOUT + 1);

  enum_state_e      st;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_exp;
  logic             seq_launch;
  logic             seq_home;
  logic             seq_armed;

  // Named internal events, observed by the bound checker
  logic evt_accept;
  logic evt_reject;
  logic evt_timeout;
  logic exp_return;
  logic evt_lap_miss;
  logic tok_d;

  seek_timer #(.TMR_W(TMR_W), .TIMEOUT(TIMEOUT)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (st == ST_BOOT),
    .count_en (st == ST_SEEK),
    .value    (tmr_val),
    .expired  (tmr_exp)
  );

  ring_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (evt_accept),
    .active      (st == ST_RUN),
    .lap_len     (phase_count),
    .launch_next (seq_launch),
    .at_home     (seq_home),
    .armed       (seq_armed)
  );

  fault_latch u_flt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_reject | evt_timeout | evt_lap_miss),
    .flag_o (chain_fault)
  );

  assign evt_accept   = (st == ST_SEEK) && ring_tok_in &&  lap_ok(32'(tmr_val), 32'(MAX_PHASES));
  assign evt_reject   = (st == ST_SEEK) && ring_tok_in && !lap_ok(32'(tmr_val), 32'(MAX_PHASES));
  assign evt_timeout  = (st == ST_SEEK) && !ring_tok_in && tmr_exp;
  assign exp_return   = (st == ST_RUN) && seq_home && seq_armed;
  assign evt_lap_miss = (st == ST_RUN) && (ring_tok_in != exp_return);
  assign enum_done    = (st == ST_RUN);

  always_comb begin
    unique case (st)
      ST_BOOT: tok_d = 1'b1;
      ST_SEEK: tok_d = evt_accept;
      ST_RUN:  tok_d = seq_launch;
      default: tok_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_BOOT;
      ring_tok_out <= 1'b0;
      phase_count  <= '0;
    end else begin
      ring_tok_out <= tok_d;
      unique case (st)
        ST_BOOT: st <= ST_SEEK;
        ST_SEEK: begin
          if (evt_accept) begin
            st          <= ST_RUN;
            phase_count <= CNT_W'(tmr_val);
          end else if (evt_reject || evt_timeout) begin
            st <= ST_DEAD;
          end
        end
        ST_RUN:  st <= ST_RUN;
        default: st <= ST_DEAD;
      endcase
    end
  end
endmodule

// File: rtl/ring_enum_checker.sv
module ring_enum_checker #(
  parameter int MAX_PHASES = 16
)(
  input logic                                clk,
  input logic                                rst_n,
  input logic                                ring_tok_out,
  input logic                                enum_done,
  input logic [$clog2(MAX_PHASES+1)-1:0]     phase_count,
  input logic                                chain_fault,
  input logic                                evt_accept,
  input logic                                evt_reject,
  input logic                                evt_timeout,
  input logic                                evt_lap_miss
);
  localparam int CNT_W = $clog2(MAX_PHASES + 1);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!ring_tok_out && !enum_done && !chain_fault && phase_count == '0));

  assert_single_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enum_done && ring_tok_out) |=> (!ring_tok_out || enum_done));

  assert_accept_relaunch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (enum_done && ring_tok_out && !chain_fault));

  assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enum_done |=> enum_done);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enum_done |-> (phase_count >= CNT_W'(1) && phase_count <= CNT_W'(MAX_PHASES)));

  assert_reject_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reject |=> (chain_fault && !enum_done));

  assert_timeout_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_timeout |=> (chain_fault && !enum_done && !ring_tok_out));

  assert_run_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enum_done && ring_tok_out && phase_count > CNT_W'(1)) |=> !ring_tok_out);

  assert_lap_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lap_miss |=> (chain_fault && enum_done));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chain_fault |=> chain_fault);
endmodule

bind phase_ring_enum ring_enum_checker #(.MAX_PHASES(MAX_PHASES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ring_tok_out (ring_tok_out),
  .enum_done    (enum_done),
  .phase_count  (phase_count),
  .chain_fault  (chain_fault),
  .evt_accept   (evt_accept),
  .evt_reject   (evt_reject),
  .evt_timeout  (evt_timeout),
  .evt_lap_miss (evt_lap_miss)
);

// File: tb/tb_phase_ring_enum.sv
module tb_phase_ring_enum;
  localparam int CLK_PERIOD = 10;
  localparam int MAXR       = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tok_out;
  logic       tok_in;
  logic       done;
  logic [4:0] count;
  logic       fault;

  int         ring_len = 1;
  logic       brk = 1'b0;
  logic       inj = 1'b0;
  logic [MAXR-1:0] cells;
  logic       tap;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Ring of single-register phase cells
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells <= '0;
    else        cells <= {cells[MAXR-2:0], tok_out};
  end
  assign tap    = (ring_len == 0) ? tok_out : cells[ring_len-1];
  assign tok_in = brk ? 1'b0 : (inj ? 1'b1 : tap);

  phase_ring_enum dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ring_tok_out (tok_out),
    .ring_tok_in  (tok_in),
    .enum_done    (done),
    .phase_count  (count),
    .chain_fault  (fault)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Leaves the bench at the negedge right after the launch edge (index 0)
  task automatic start_ring(input int len, input logic brk_v);
    @(negedge clk);
    rst_n = 1'b0; ring_len = len; brk = brk_v; inj = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!tok_out && !done && !fault && count == 0, "R1 reset outputs",
        {tok_out, done, fault, count}, 0);
  endtask

  task automatic t_enum(input int n);
    int bad = 0;
    start_ring(n, 1'b0);
    chk(tok_out == 1'b1, "R2 launch pulse", tok_out, 1);
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (tok_out || done || fault) bad++;
    end
    chk(bad == 0, "R2 quiet during seek", bad, 0);
    @(negedge clk);
    chk(done == 1'b1 && !fault, "R3 done at return", done, 1);
    chk(count == 5'(n), "R3 phase count", count, n);
    chk(tok_out == 1'b1, "R6 first run launch", tok_out, 1);
    bad = 0;
    for (int m = 1; m <= 4*n + 2; m++) begin
      @(negedge clk);
      if (tok_out != ((m % n) == 0) || fault || !done) bad++;
    end
    chk(bad == 0, "R6 one token per N clocks", bad, 0);
  endtask

  task automatic t_direct();
    start_ring(0, 1'b0);
    @(negedge clk);
    chk(fault == 1'b1 && !done, "R4 zero-length loop", {fault, done}, 2);
  endtask

  task automatic t_too_long();
    start_ring(17, 1'b0);
    repeat (17) @(negedge clk);
    chk(fault == 1'b0, "R4 no fault before return", fault, 0);
    @(negedge clk);
    chk(fault == 1'b1 && !done, "R4 ring of 17 rejected", {fault, done}, 2);
  endtask

  task automatic t_timeout();
    int bad = 0;
    start_ring(5, 1'b1);
    repeat (32) @(negedge clk);
    chk(fault == 1'b0 && !done, "R5 no fault at 32", {fault, done}, 0);
    @(negedge clk);
    chk(fault == 1'b1 && !done, "R5 timeout fault at 33", {fault, done}, 2);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!fault || tok_out || done) bad++;
    end
    chk(bad == 0, "R8 fault held, token silent", bad, 0);
  endtask

  task automatic t_run_extra();
    int ones = 0;
    start_ring(4, 1'b0);
    repeat (5 + 9) @(negedge clk);
    chk(done && !fault && !tok_out, "R7 clean before injection", {done, fault, tok_out}, 4);
    inj = 1'b1;
    @(negedge clk);
    inj = 1'b0;
    chk(fault == 1'b1 && done == 1'b1, "R7 extra return flagged", {fault, done}, 3);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      ones += int'(tok_out);
    end
    chk(ones == 2, "R7 circulation continues", ones, 2);
    chk(fault == 1'b1, "R8 fault sticky in run", fault, 1);
  endtask

  task automatic t_run_missing();
    start_ring(3, 1'b0);
    repeat (7) @(negedge clk);
    chk(done && !fault, "R7 clean before break", {done, fault}, 2);
    brk = 1'b1;
    repeat (3) @(negedge clk);
    chk(fault == 1'b1 && done == 1'b1, "R7 missing return flagged", {fault, done}, 3);
    brk = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_enum(1);
    t_enum(3);
    t_enum(7);
    t_enum(16);
    t_direct();
    t_too_long();
    t_timeout();
    t_run_extra();
    t_run_missing();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule